// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor Core

This block is a small sequential processor that runs a program held in its own unified code-and-data memory. It keeps one working register (the accumulator), a program counter, an instruction register and three comparison flags (greater, equal, less). It steps through fetch, decode and execute, plus a write-back step for instructions that modify a memory word. It repeats this until it executes the stop instruction. Each 16-bit instruction has a 4-bit operation code in bits [15:12] and one operand address in bits [11:0]. The core uses the low `ADDR_W` bits of that address, so memory holds 2^ADDR_W words.

A host fills the memory through a load port while reset is held. It then releases reset, and the core starts at address 0. Two instructions talk to the outside world. The input instruction waits on a valid/ready handshake and stores the accepted word into memory. The output instruction presents a memory word and holds it until the receiver is ready. The `halted` output rises when the core stops and stays high until the next reset.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `halted`, `out_valid` and `in_ready` are 0. After reset, execution starts at address 0 with the accumulator at 0 and all three flags at 0.
- R2: While `rst` is high, each cycle with `ld_we`=1 writes `ld_data` into word `ld_addr`. The core writes no memory while `rst` is high.
- R3: Opcode 0 (load) copies word X into the accumulator. Opcode 3 (add) sets the accumulator to accumulator+word X, and opcode 5 (subtract) sets it to accumulator−word X. Both wrap modulo 2^16.
- R4: Opcode 1 (store) writes the accumulator into word X.
- R5: Opcode 2 writes 0 into word X. Opcode 4 adds 1 to word X and opcode 6 subtracts 1 from it, both wrapping. None of these three changes the accumulator.
- R6: Opcode 7 (compare) treats word X and the accumulator as unsigned. It sets exactly one flag: greater if word X > accumulator, equal if they are equal, less otherwise.
- R7: Opcode 8 always loads X into the program counter. Opcodes 9, 10 and 11 jump when greater, equal or less is 1. Opcode 12 jumps when equal is 0.
- R8: Any instruction other than a taken jump passes control to the next address in sequence.
- R9: Opcode 13 (input) raises `in_ready` and stalls until `in_valid` is 1. It then writes `in_data` into word X.
- R10: Opcode 14 (output) raises `out_valid` with word X on `out_data`. Both stay unchanged until `out_ready` is 1, and execution does not advance before that.
- R11: Opcode 15 (stop) sets `halted`. After that, no instruction runs and no handshake output rises until `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables memory loading |
| ld_we | input | 1 | Memory load write enable (honoured only while `rst`=1) |
| ld_addr | input | ADDR_W | Memory load word address |
| ld_data | input | DATA_W | Memory load word |
| in_valid | input | 1 | Input word available |
| in_ready | output | 1 | Core is executing an input instruction and can accept |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Core is presenting an output word |
| out_ready | input | 1 | Receiver accepts the output word |
| out_data | output | DATA_W | Output word (memory word X) |
| halted | output | 1 | Core has executed the stop instruction |

## Verification
Internal state is visible at the ports only through the output instruction. A wrong accumulator, flag or memory word therefore shows up in the value the next output instruction presents, usually within a few instructions. A wrong flag or program counter shows up as a different output sequence, or as `halted` rising earlier or later than expected. The bench sweeps operand pairs that include zero, one and the wrap and sign boundaries through every arithmetic, memory-direct, compare and jump opcode, and computes the expected outputs arithmetically. Stalls are checked directly at the handshake pins.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [3:0] {
        OP_LOAD  = 4'h0,
        OP_STORE = 4'h1,
        OP_CLEAR = 4'h2,
        OP_ADD   = 4'h3,
        OP_INC   = 4'h4,
        OP_SUB   = 4'h5,
        OP_DEC   = 4'h6,
        OP_CMP   = 4'h7,
        OP_JMP   = 4'h8,
        OP_JGT   = 4'h9,
        OP_JEQ   = 4'hA,
        OP_JLT   = 4'hB,
        OP_JNE   = 4'hC,
        OP_IN    = 4'hD,
        OP_OUT   = 4'hE,
        OP_HALT  = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_WBACK,
        ST_STOP
    } phase_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cond_t;

    localparam int OPC_W = 4;

    function automatic logic branch_taken(opcode_e op, cond_t c);
        case (op)
            OP_JMP:  return 1'b1;
            OP_JGT:  return c.gt;
            OP_JEQ:  return c.eq;
            OP_JLT:  return c.lt;
            OP_JNE:  return ~c.eq;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic writes_back(opcode_e op);
        return (op == OP_CLEAR) || (op == OP_INC) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] acc_next,
    output logic [DATA_W-1:0] word_next,
    output cond_t             cmp
);
    always_comb begin
        case (op)
            OP_LOAD: acc_next = word;
            OP_ADD:  acc_next = acc + word;
            OP_SUB:  acc_next = acc - word;
            default: acc_next = acc;
        endcase
    end

    always_comb begin
        case (op)
            OP_CLEAR: word_next = '0;
            OP_INC:   word_next = word + DATA_W'(1);
            OP_DEC:   word_next = word - DATA_W'(1);
            default:  word_next = word;
        endcase
    end

    assign cmp.gt = word > acc;
    assign cmp.eq = word == acc;
    assign cmp.lt = word < acc;
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output opcode_e           op,
    output logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] alu_acc,
    input  logic [DATA_W-1:0] alu_word,
    input  cond_t             alu_cmp,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              halted
);
    localparam int OPC_LSB = DATA_W - OPC_W;

    phase_e            phase_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] wb_q;
    cond_t             flags_q;
    logic [ADDR_W-1:0] opnd;

    assign op   = opcode_e'(ir_q[DATA_W-1 -: OPC_W]);
    assign opnd = ir_q[ADDR_W-1:0];
    assign acc  = acc_q;

    generate
        if (ADDR_W < OPC_LSB) begin : g_spare
            logic unused_hi;
            assign unused_hi = ^ir_q[OPC_LSB-1:ADDR_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
            acc_q   <= '0;
            wb_q    <= '0;
            flags_q <= '0;
        end else begin
            case (phase_q)
                ST_FETCH: begin
                    ir_q    <= mem_rdata;
                    pc_q    <= pc_q + ADDR_W'(1);
                    phase_q <= ST_DECODE;
                end
                ST_DECODE: phase_q <= ST_EXEC;
                ST_EXEC: begin
                    phase_q <= ST_FETCH;
                    case (op)
                        OP_LOAD, OP_ADD, OP_SUB: acc_q <= alu_acc;
                        OP_CMP: flags_q <= alu_cmp;
                        OP_CLEAR, OP_INC, OP_DEC: begin
                            wb_q    <= alu_word;
                            phase_q <= ST_WBACK;
                        end
                        OP_JMP, OP_JGT, OP_JEQ, OP_JLT, OP_JNE: begin
                            if (branch_taken(op, flags_q)) pc_q <= opnd;
                        end
                        OP_IN: begin
                            if (in_valid) begin
                                wb_q    <= in_data;
                                phase_q <= ST_WBACK;
                            end else begin
                                phase_q <= ST_EXEC;
                            end
                        end
                        OP_OUT: if (!out_ready) phase_q <= ST_EXEC;
                        OP_HALT: phase_q <= ST_STOP;
                        default: ;
                    endcase
                end
                ST_WBACK: phase_q <= ST_FETCH;
                default:  phase_q <= ST_STOP;
            endcase
        end
    end

    logic in_exec;
    assign in_exec   = (phase_q == ST_EXEC);
    assign mem_raddr = (phase_q == ST_FETCH) ? pc_q : opnd;
    assign mem_we    = (in_exec && op == OP_STORE) || (phase_q == ST_WBACK);
    assign mem_waddr = opnd;
    assign mem_wdata = (phase_q == ST_WBACK) ? wb_q : acc_q;
    assign in_ready  = in_exec && (op == OP_IN);
    assign out_valid = in_exec && (op == OP_OUT);
    assign halted    = (phase_q == ST_STOP);

    logic unused_wb;
    assign unused_wb = writes_back(op);
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              halted
);
    logic [ADDR_W-1:0] core_raddr, core_waddr, mem_waddr;
    logic [DATA_W-1:0] core_wdata, mem_wdata, mem_rdata;
    logic              core_we, mem_we;
    logic [DATA_W-1:0] acc, alu_acc, alu_word;
    opcode_e           op;
    cond_t             alu_cmp;

    assign mem_we    = rst ? ld_we   : core_we;
    assign mem_waddr = rst ? ld_addr : core_waddr;
    assign mem_wdata = rst ? ld_data : core_wdata;
    assign out_data  = mem_rdata;

    acc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (core_raddr),
        .rdata (mem_rdata)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .op        (op),
        .acc       (acc),
        .word      (mem_rdata),
        .acc_next  (alu_acc),
        .word_next (alu_word),
        .cmp       (alu_cmp)
    );

    acc_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_raddr (core_raddr),
        .mem_we    (core_we),
        .mem_waddr (core_waddr),
        .mem_wdata (core_wdata),
        .op        (op),
        .acc       (acc),
        .alu_acc   (alu_acc),
        .alu_word  (alu_word),
        .alu_cmp   (alu_cmp),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .halted    (halted)
    );
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              halted,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [2:0]        cmp
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !halted && !out_valid && !in_ready); // R1

    AST_CMP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(cmp) == 1); // R6

    AST_IN_STALL: assert property (@(posedge clk) disable iff (rst)
        in_ready && !in_valid |=> in_ready); // R9

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R11

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        halted |-> !out_valid && !in_ready); // R11
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .halted    (halted),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .cmp       (alu_cmp)
);

// File: tb/acc_core_test.sv
`timescale 1ns/1ps
module acc_core_test;
    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic          in_valid;
    logic          in_ready;
    logic [DW-1:0] in_data;
    logic          out_valid;
    logic          out_ready;
    logic [DW-1:0] out_data;
    logic          halted;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] outq[$];
    logic [DW-1:0] inq[$];
    logic          in_pend = 1'b0;
    logic          ready_drv = 1'b1;

    always #4 clk = ~clk;

    acc_core #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .halted(halted)
    );

    assign out_ready = ready_drv;
    assign in_valid  = (inq.size() > 0);
    assign in_data   = (inq.size() > 0) ? inq[0] : '0;

    always @(negedge clk) begin
        if (in_pend) begin
            void'(inq.pop_front());
            in_pend = 1'b0;
        end
        if (!rst && in_valid && in_ready) in_pend = 1'b1;
        if (!rst && out_valid && out_ready) outq.push_back(out_data);
    end

    task automatic check(input logic ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ins(input logic [3:0] op, input int a);
        return {op, 12'(a)};
    endfunction

    task automatic begin_load();
        @(negedge clk);
        rst = 1'b1;
        ld_we = 1'b0;
        outq.delete();
        @(negedge clk);
    endtask

    task automatic pw(input int a, input logic [DW-1:0] d);
        ld_we = 1'b1;
        ld_addr = AW'(a);
        ld_data = d;
        @(negedge clk);
    endtask

    task automatic start();
        ld_we = 1'b0;
        rst = 1'b0;
    endtask

    task automatic wait_halt(input string tag);
        int n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(halted, tag, {15'b0, halted}, 16'h1);
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] vals[5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
        logic [DW-1:0] cv[4]   = '{16'h0000, 16'h0001, 16'h0005, 16'hFFFF};

        // R1: reset state and post-reset R=0, flags cleared; R2 loading; R8 fall-through
        begin_load();
        check(!halted && !out_valid && !in_ready, "R1 idle in reset",
              {13'b0, halted, out_valid, in_ready}, 16'h0);
        pw(0, ins(4'hC, 3)); pw(1, ins(4'hE, 110)); pw(2, ins(4'hF, 0));
        pw(3, ins(4'h1, 100)); pw(4, ins(4'hE, 100)); pw(5, ins(4'h9, 8));
        pw(6, ins(4'hE, 110)); pw(7, ins(4'hF, 0)); pw(8, ins(4'hE, 111));
        pw(9, ins(4'hF, 0));
        pw(100, 16'h1234); pw(110, 16'hAAAA); pw(111, 16'h5555);
        start();
        @(negedge clk);
        check(!halted && !out_valid && !in_ready, "R1 first cycle",
              {13'b0, halted, out_valid, in_ready}, 16'h0);
        wait_halt("R1 halt");
        check(outq.size() == 2, "R1 output count", 16'(outq.size()), 16'd2);
        if (outq.size() == 2) begin
            check(outq[0] == 16'h0000, "R1 acc zero after reset (R4 store)", outq[0], 16'h0);
            check(outq[1] == 16'hAAAA, "R1 flags clear, R8 fall-through", outq[1], 16'hAAAA);
        end

        // R3 / R4: load, add, subtract sweep
        foreach (vals[i]) foreach (vals[j]) begin
            begin_load();
            pw(0, ins(4'h0, 100)); pw(1, ins(4'h3, 101)); pw(2, ins(4'h1, 102));
            pw(3, ins(4'hE, 102)); pw(4, ins(4'h0, 100)); pw(5, ins(4'h5, 101));
            pw(6, ins(4'h1, 103)); pw(7, ins(4'hE, 103)); pw(8, ins(4'hF, 0));
            pw(100, vals[i]); pw(101, vals[j]); pw(102, 16'hDEAD); pw(103, 16'hDEAD);
            start();
            wait_halt("R3 halt");
            check(outq.size() == 2, "R3 output count", 16'(outq.size()), 16'd2);
            if (outq.size() == 2) begin
                check(outq[0] == 16'(vals[i] + vals[j]), "R3 add", outq[0], 16'(vals[i] + vals[j]));
                check(outq[1] == 16'(vals[i] - vals[j]), "R3 sub", outq[1], 16'(vals[i] - vals[j]));
            end
        end

        // R5: clear / increment / decrement in memory, accumulator untouched
        foreach (vals[i]) begin
            begin_load();
            pw(0, ins(4'h0, 103)); pw(1, ins(4'h4, 100)); pw(2, ins(4'hE, 100));
            pw(3, ins(4'h6, 101)); pw(4, ins(4'hE, 101)); pw(5, ins(4'h2, 102));
            pw(6, ins(4'hE, 102)); pw(7, ins(4'h1, 104)); pw(8, ins(4'hE, 104));
            pw(9, ins(4'hF, 0));
            pw(100, vals[i]); pw(101, vals[i]); pw(102, 16'h1234); pw(103, 16'h5A5A);
            start();
            wait_halt("R5 halt");
            check(outq.size() == 4, "R5 output count", 16'(outq.size()), 16'd4);
            if (outq.size() == 4) begin
                check(outq[0] == 16'(vals[i] + 1), "R5 increment", outq[0], 16'(vals[i] + 1));
                check(outq[1] == 16'(vals[i] - 1), "R5 decrement", outq[1], 16'(vals[i] - 1));
                check(outq[2] == 16'h0000, "R5 clear", outq[2], 16'h0);
                check(outq[3] == 16'h5A5A, "R5 acc unchanged", outq[3], 16'h5A5A);
            end
        end

        // R6 / R7 / R8: compare (word vs acc, unsigned) then each jump opcode
        foreach (cv[i]) foreach (cv[j]) for (int jo = 8; jo <= 12; jo++) begin
            logic tk;
            logic [DW-1:0] e;
            case (jo)
                8:  tk = 1'b1;
                9:  tk = cv[i] > cv[j];
                10: tk = cv[i] == cv[j];
                11: tk = cv[i] < cv[j];
                default: tk = cv[i] != cv[j];
            endcase
            e = tk ? 16'h5555 : 16'hAAAA;
            begin_load();
            pw(0, ins(4'h0, 101)); pw(1, ins(4'h7, 100)); pw(2, ins(4'(jo), 5));
            pw(3, ins(4'hE, 110)); pw(4, ins(4'hF, 0)); pw(5, ins(4'hE, 111));
            pw(6, ins(4'hF, 0));
            pw(100, cv[i]); pw(101, cv[j]); pw(110, 16'hAAAA); pw(111, 16'h5555);
            start();
            wait_halt("R7 halt");
            check(outq.size() == 1 && outq[0] == e, "R6/R7 compare+jump",
                  (outq.size() > 0) ? outq[0] : 16'hFFFF, e);
        end

        // R9: input stalls until valid, then writes word X
        begin_load();
        pw(0, ins(4'hD, 100)); pw(1, ins(4'hD, 101)); pw(2, ins(4'h0, 101));
        pw(3, ins(4'h5, 100)); pw(4, ins(4'h1, 102)); pw(5, ins(4'hE, 100));
        pw(6, ins(4'hE, 102)); pw(7, ins(4'hF, 0));
        start();
        repeat (12) @(negedge clk);
        check(in_ready && !halted && outq.size() == 0, "R9 stall without valid",
              {14'b0, in_ready, halted}, 16'h2);
        inq.push_back(16'h0030);
        repeat (6) @(negedge clk);
        check(in_ready && inq.size() == 0, "R9 waiting for second input",
              {15'b0, in_ready}, 16'h1);
        inq.push_back(16'h0100);
        wait_halt("R9 halt");
        check(outq.size() == 2, "R9 output count", 16'(outq.size()), 16'd2);
        if (outq.size() == 2) begin
            check(outq[0] == 16'h0030, "R9 first input stored", outq[0], 16'h0030);
            check(outq[1] == 16'h00D0, "R9 second input used", outq[1], 16'h00D0);
        end

        // R10: output held under backpressure
        begin_load();
        pw(0, ins(4'hE, 100)); pw(1, ins(4'hE, 101)); pw(2, ins(4'hF, 0));
        pw(100, 16'hBEEF); pw(101, 16'hCAFE);
        ready_drv = 1'b0;
        start();
        repeat (4) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            check(out_valid && out_data == 16'hBEEF && !halted, "R10 held while not ready",
                  out_data, 16'hBEEF);
            @(negedge clk);
        end
        ready_drv = 1'b1;
        wait_halt("R10 halt");
        check(outq.size() == 2 && outq[0] == 16'hBEEF && outq[1] == 16'hCAFE,
              "R10 accepted in order", (outq.size() > 0) ? outq[0] : 16'hFFFF, 16'hBEEF);

        // R11: stop is sticky and silent; reset clears it
        begin_load();
        pw(0, ins(4'hF, 0)); pw(1, ins(4'hE, 100)); pw(100, 16'h7777);
        start();
        wait_halt("R11 halt");
        repeat (20) @(negedge clk);
        check(halted && !out_valid && !in_ready && outq.size() == 0, "R11 stays stopped",
              {13'b0, halted, out_valid, in_ready}, 16'h4);
        begin_load();
        check(!halted, "R11 cleared by reset", {15'b0, halted}, 16'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule